// File: doc/BRIEF.md
# Three-Wire Converter Read Controller

This block is a host-side master that fetches 16-bit results from a serial analog-to-digital converter over three wires: an active-low chip select, a serial clock it drives, and a serial data line it receives. A one-cycle start request begins a read. The controller pulls chip select low while its serial clock is idling low, which is the condition the converter needs before it presents its result. It then clocks out sixteen bits, MSB first, and returns the assembled word with a one-cycle done pulse.

The serial clock comes from the system clock through a divider. The high and low phases are each `DIV_HALF` system clocks long. The converter changes its data line after every falling clock edge, so the controller captures the line at every rising edge it drives.

The converter starts a new conversion whenever a read ends, either normally or by an early chip-select rise. It also starts one after power-up. The controller therefore holds chip select high for at least `CONV_WAIT` system clocks after reset and after every read before it starts the next one. An abort input ends a read in progress at once.

Top module: `adc3w_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0, `done` is 0 and `rd_data` is 0.
- R2: `cs_n` falls only while `sclk` is low, and `sclk` rises only while `cs_n` is low.
- R3: While `cs_n` is low, the first rising edge of `sclk` comes `DIV_HALF` system clocks after `cs_n` falls. Every later high phase and every later low phase of `sclk` lasts exactly `DIV_HALF` system clocks.
- R4: A read produces exactly 16 rising edges of `sclk`. `sdi` is captured at each rising edge. The first captured bit becomes `rd_data[15]` and the last becomes `rd_data[0]`.
- R5: On the system clock after the 16th falling edge of `sclk`, `cs_n` returns to 1, `done` is 1 for exactly one cycle, `busy` is 0 and `rd_data` holds the received word.
- R6: `cs_n` stays high for at least `CONV_WAIT` system clocks after reset is released and after every rise of `cs_n`. A start that arrives during this wait is held, and the read begins when the wait expires.
- R7: `busy` rises on the clock after an accepted start and stays high until done or abort. A start while `busy` is high has no effect: no second read follows the current one.
- R8: When abort is asserted while `busy` is high, then on the next clock `cs_n` is 1, `sclk` is 0 and `busy` is 0. No done pulse follows, and `rd_data` keeps the word of the last completed read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to read a result |
| abort | input | 1 | End the current read immediately, with no result |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A read is pending or in progress |
| done | output | 1 | One-cycle pulse when `rd_data` is updated |
| rd_data | output | 16 | Last completed result |

## Verification
The read path is driven with words that separate specific faults:
- alternating and mixed bit patterns expose bit-order and off-by-one capture errors;
- all-zero and all-one words expose a stuck data path;
- words with only the end bits set (or clear) show whether the first and last captures land in the MSB and LSB.

A converter model changes `sdi` on each falling edge. Because of this, a controller that samples on the wrong edge returns a shifted word.

A timing monitor checks every serial clock phase length, the chip-select gap and the clock level at each chip-select fall. The directed cases cover the following:
- an abort halfway through a transfer;
- a second start during a read;
- a start issued before the post-reset conversion time has elapsed.

// File: rtl/adc3w_pkg.sv
// Shared types of the three-wire converter reader.
package adc3w_pkg;

    // Read sequence phases of the controller.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // no request pending
        ST_HOLD  = 3'd1,   // request accepted, conversion time not yet over
        ST_SETUP = 3'd2,   // chip select low, first clock low phase
        ST_SHIFT = 3'd3,   // serial clock toggling, bits arriving
        ST_END   = 3'd4    // last falling edge given, finish the read
    } rd_state_t;

endpackage

// File: rtl/adc3w_clkdiv.sv
// Serial clock phase divider.
// Counts system clocks while run is high and pulses tick once every
// HALF cycles; each tick marks the end of one serial clock phase.
// Assumes HALF >= 1. The count restarts from zero whenever run is low.
module adc3w_clkdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Phase counter: wraps at the phase length, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // End-of-phase strobe.
    always_comb begin
        tick = run && (cnt == LAST);
    end

    // R3: a tick never occurs twice in a row unless the phase is one cycle long
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && HALF > 1) |=> !tick);

endmodule

// File: rtl/adc3w_convtimer.sv
// Conversion wait timer.
// Loads WAIT on reset and on reload, then counts down to zero; ready is
// high once the converter has had the full conversion time.
// Assumes reload is pulsed on the cycle chip select returns high.
module adc3w_convtimer #(
    parameter int WAIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic ready
);
    localparam int TW = (WAIT > 0) ? $clog2(WAIT + 1) : 1;
    localparam logic [TW-1:0] LOADV = TW'(WAIT);

    logic [TW-1:0] remain;

    // Countdown: restart on reset or reload, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            remain <= LOADV;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Ready once the countdown has run out.
    always_comb begin
        ready = (remain == '0);
    end

    generate
        if (WAIT > 0) begin : g_wait_chk
            // R6: a fresh conversion always blocks the next read for a while
            a_r6_reload_blocks: assert property (@(posedge clk) disable iff (!rst_n)
                reload |=> !ready);
        end
    endgenerate

endmodule

// File: rtl/adc3w_shift.sv
// Serial-to-parallel capture register.
// Shifts din in at the LSB end on each en cycle, so the first bit taken
// ends up at the MSB after W shifts. Assumes W >= 2.
module adc3w_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Capture one serial bit per enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], din};
        end
    end

endmodule

// File: rtl/adc3w_reader.sv
// Three-wire converter read controller (top).
// On start, waits out the converter's conversion time, lowers cs_n with
// sclk low, drives WORD_W serial clocks of equal phases and captures sdi
// on each rising edge. After the last falling edge it raises cs_n and
// pulses done with the word. abort ends a read at once with no result.
// Assumes sdi changes after each falling sclk edge and is stable at the
// following rising edge; all inputs synchronous to clk.
module adc3w_reader
    import adc3w_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int DIV_HALF  = 4,
    parameter int CONV_WAIT = 4162500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              sdi,
    output logic              cs_n,
    output logic              sclk,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data
);
    localparam int BCW = $clog2(WORD_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W - 1);

    rd_state_t          state;
    logic [BCW-1:0]     bit_cnt;
    logic [WORD_W-1:0]  shift_word;
    logic               div_run;
    logic               div_tick;
    logic               conv_ready;
    logic               conv_reload;
    logic               shift_en;
    logic               abort_hit;

    // Decode control strobes for the submodules.
    always_comb begin
        abort_hit   = abort && busy;
        div_run     = (state == ST_SETUP) || (state == ST_SHIFT);
        shift_en    = div_tick && !sclk && !abort_hit;
        conv_reload = !cs_n && (abort_hit || (state == ST_END));
    end

    adc3w_clkdiv #(
        .HALF (DIV_HALF)
    ) u_clkdiv (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (div_run),
        .tick (div_tick)
    );

    adc3w_convtimer #(
        .WAIT (CONV_WAIT)
    ) u_convtimer (
        .clk   (clk),
        .rst_n (rst_n),
        .reload(conv_reload),
        .ready (conv_ready)
    );

    adc3w_shift #(
        .W (WORD_W)
    ) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (shift_en),
        .din  (sdi),
        .q    (shift_word)
    );

    // Read sequencer: drives chip select, serial clock, busy and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            bit_cnt <= '0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (abort_hit) begin
                state <= ST_IDLE;
                cs_n  <= 1'b1;
                sclk  <= 1'b0;
                busy  <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) begin
                            busy <= 1'b1;
                            if (conv_ready) begin
                                state <= ST_SETUP;
                                cs_n  <= 1'b0;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (conv_ready) begin
                            state <= ST_SETUP;
                            cs_n  <= 1'b0;
                        end
                    end
                    ST_SETUP: begin
                        bit_cnt <= '0;
                        if (div_tick) begin
                            sclk  <= 1'b1;
                            state <= ST_SHIFT;
                        end
                    end
                    ST_SHIFT: begin
                        if (div_tick) begin
                            if (sclk) begin
                                sclk <= 1'b0;
                                if (bit_cnt == LAST_BIT) begin
                                    state <= ST_END;
                                end else begin
                                    bit_cnt <= bit_cnt + 1'b1;
                                end
                            end else begin
                                sclk <= 1'b1;
                            end
                        end
                    end
                    ST_END: begin
                        cs_n    <= 1'b1;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        rd_data <= shift_word;
                        state   <= ST_IDLE;
                    end
                    default: begin
                        state <= ST_IDLE;
                        cs_n  <= 1'b1;
                        sclk  <= 1'b0;
                        busy  <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R2: readout is entered only with the serial clock idling low
    a_r2_sclk_low_at_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk);

    // R2: the serial clock rises only inside a selected transfer
    a_r2_sclk_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

    // R5: done comes with chip select released and busy cleared
    a_r5_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy && !sclk));

    // R5: done lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy rises only in answer to a start request
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8: abort ends the read next cycle with no done
    a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (cs_n && !sclk && !busy && !done));

    // R8: the result changes only together with done
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));

endmodule

// File: tb/adc3w_reader_bench.sv
// Self-checking bench for the three-wire converter read controller.
module adc3w_reader_bench;
    localparam int HALF  = 3;
    localparam int WAIT  = 40;
    localparam int W     = 16;
    localparam int NVEC  = 6;

    // Words presented by the converter model; each is also the expected result.
    localparam logic [W-1:0] VEC [NVEC] = '{
        16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'h1234
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         abort = 1'b0;
    logic         sdi;
    logic         cs_n;
    logic         sclk;
    logic         busy;
    logic         done;
    logic [W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    adc3w_reader #(
        .WORD_W   (W),
        .DIV_HALF (HALF),
        .CONV_WAIT(WAIT)
    ) u_adc3w_reader (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .abort  (abort),
        .sdi    (sdi),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .busy   (busy),
        .done   (done),
        .rd_data(rd_data)
    );

    // Converter model: MSB valid at select, next bit after each falling edge.
    logic [W-1:0] dev_word = '0;
    int           fall_cnt = 0;
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) fall_cnt <= 0;
        else      fall_cnt <= fall_cnt + 1;
    end
    assign sdi = (fall_cnt < W) ? dev_word[W-1-fall_cnt] : 1'b0;

    // Timing monitor sampled between clock edges.
    int   gap_cnt = 0, run_len = 0, rises = 0, cs_falls = 0;
    int   phase_bad = 0, gap_bad = 0, sck_bad = 0, done_cnt = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            gap_cnt = 0; run_len = 0; rises = 0;
            prev_sclk = 1'b0; prev_cs = 1'b1;
        end else begin
            if (done) done_cnt++;
            if (cs_n) begin
                gap_cnt++;
                run_len = 0;
                if (sclk) sck_bad++;
            end else if (prev_cs) begin
                cs_falls++;
                if (gap_cnt < WAIT) gap_bad++;
                if (sclk) sck_bad++;
                gap_cnt = 0; rises = 0; run_len = 1;
            end else if (sclk == prev_sclk) begin
                run_len++;
            end else begin
                if (run_len != HALF) phase_bad++;
                if (sclk) rises++;
                run_len = 1;
            end
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Issue a start and wait for done; returns 1 if done was seen.
    task automatic start_and_wait(output bit seen);
        seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", 32'(busy), 32'd1);
        for (int i = 0; i < 4000; i++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic full_read(input logic [W-1:0] w, input string tag);
        bit seen;
        dev_word = w;
        start_and_wait(seen);
        check(seen, "R5", {tag, " done seen"}, 32'(seen), 32'd1);
        check(rd_data == w, "R4", {tag, " word"}, 32'(rd_data), 32'(w));
        check(rises == W, "R4", {tag, " rising edges"}, 32'(rises), 32'(W));
        check(cs_n && !busy && !sclk, "R5", {tag, " released"},
              {29'd0, cs_n, busy, sclk}, 32'h4);
        @(negedge clk);
        check(!done, "R5", {tag, " done width"}, 32'(done), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "WDOG", "watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        int falls_before;
        bit seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1", "cs_n", 32'(cs_n), 32'd1);
        check(sclk == 1'b0, "R1", "sclk", 32'(sclk), 32'd0);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done",
              {30'd0, busy, done}, 32'd0);
        check(rd_data == '0, "R1", "rd_data", 32'(rd_data), 32'd0);

        // Vector walk; the first read starts early and must wait (R6).
        for (int v = 0; v < NVEC; v++) begin
            full_read(VEC[v], $sformatf("vec%0d", v));
        end

        // R7: a second start during a read launches nothing more
        dev_word = 16'h5A5A;
        falls_before = cs_falls;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (WAIT + 20) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
        check(rd_data == 16'h5A5A, "R7", "word with extra start", 32'(rd_data), 32'h5A5A);
        repeat (3 * WAIT) @(negedge clk);
        check(cs_falls == falls_before + 1, "R7", "reads launched",
              32'(cs_falls), 32'(falls_before + 1));
        check(!busy && cs_n, "R7", "idle after read", {30'd0, busy, cs_n}, 32'd1);

        // R8: abort in mid-transfer
        held = rd_data;
        dev_word = 16'hC0DE;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 4000 && rises < 5; i++) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check(cs_n && !sclk && !busy, "R8", "abort released",
              {29'd0, cs_n, sclk, busy}, 32'h4);
        done_cnt = 0;
        repeat (4 * WAIT) @(negedge clk);
        check(done_cnt == 0, "R8", "no done after abort", 32'(done_cnt), 32'd0);
        check(rd_data == held, "R8", "result kept", 32'(rd_data), 32'(held));

        // Read after abort: conversion wait restarted at abort.
        full_read(16'h0F0F, "after abort");

        // Timing rules over the whole run.
        check(phase_bad == 0, "R3", "phase lengths", 32'(phase_bad), 32'd0);
        check(gap_bad == 0, "R6", "conversion gaps", 32'(gap_bad), 32'd0);
        check(sck_bad == 0, "R2", "sclk level vs cs_n", 32'(sck_bad), 32'd0);
        seen = 1'b1;
        if (!seen) check(1'b0, "R5", "unused", 32'd0, 32'd1);
        finish_run();
    end

endmodule